// File: doc/BRIEF.md
# Daisy-Chain Serial Configuration Receiver

This block is the serial configuration input of one device in a chain of devices. All devices in the chain share one configuration clock, and the output of each device feeds the input of the next. The block samples the serial input on every rising edge and watches for a four-bit preamble. It then reads a 24-bit length count, consumes a parameterised number of framed configuration words for its own use, and afterwards acts as a one-cycle repeater toward the next device.

The header is repeated downstream, so every device captures the same length count. While this device is loading its own frames it drives its serial output high. Each frame opens with a zero start bit, and ones seen where a start bit is expected count as idle fill. Every device counts configuration clocks from reset and raises its startup trigger when that count reaches the length count. The whole chain therefore starts in the same cycle, however many frames each device took. The I/O-release flag follows the startup trigger after two clocks.

Top module: `cfg_chain_rx`

## Requirements
- R1: While reset is applied, `ser_out` is 1 and `startup`, `io_release` and `frame_valid` are 0.
- R2: Before the preamble has been found, each sampled input bit appears on `ser_out` one clock later.
- R3: The preamble is the bit sequence 0,0,1,0 in arrival order. Its bits are also repeated on `ser_out` one clock later.
- R4: The 24 bits after the preamble are captured as the length count, most significant bit first, and are repeated on `ser_out` one clock later.
- R5: During the frame phase, `ser_out` is 1. Each frame is a 0 start bit followed by FRAME_BITS data bits. Each data bit appears on `frame_bit` with `frame_valid` high one clock after it is sampled. The start bit is not presented.
- R6: A 1 sampled where a frame start bit is expected is idle fill. It produces no `frame_valid` and does not start a frame.
- R7: After the last data bit of frame NUM_FRAMES, every further input bit appears on `ser_out` one clock later.
- R8: Bits are numbered from 1, starting with the first bit sampled after reset. `startup` goes high one clock after the bit whose number equals the length count is sampled, and then stays high.
- R9: `io_release` goes high two clocks after `startup` goes high, and then stays high.
- R10: The number of `frame_valid` pulses per configuration is FRAME_BITS × NUM_FRAMES, with both values set by parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared configuration clock |
| rst_n | input | 1 | Active-low reset |
| ser_in | input | 1 | Serial configuration data, sampled on the rising edge |
| ser_out | output | 1 | Registered serial output to the next device |
| frame_valid | output | 1 | A frame data bit is presented on `frame_bit` |
| frame_bit | output | 1 | Frame data bit for this device |
| startup | output | 1 | Startup trigger, sticky |
| io_release | output | 1 | I/O release flag, sticky |

## Verification
The hardest situation to reach is the handover from frame loading to repeating. In the same stretch of the stream, idle fill between frames has to be told apart from start bits, and the startup count has to fall after the last own frame bit. The bench therefore builds complete configuration streams arithmetically. It sweeps the leading idle length, the gap of ones before each frame, the frame data patterns and the place of the length count within the forwarded tail. Every output is predicted bit by bit from the position of each bit in the stream.

// File: rtl/cfg_chain_pkg.sv
package cfg_chain_pkg;
  typedef enum logic [1:0] {
    ST_SEARCH = 2'd0,
    ST_LENGTH = 2'd1,
    ST_FRAMES = 2'd2,
    ST_PASS   = 2'd3
  } chain_state_e;

  localparam int unsigned PRE_W = 4;
  localparam logic [PRE_W-1:0] PRE_PATTERN = 4'b0010;
endpackage

// File: rtl/cfg_chain_preamble.sv
module cfg_chain_preamble #(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] PATTERN = 4'b0010
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic din,
  output logic hit
);
  logic [W-2:0] hist_q, hist_n;

  always_comb begin
    hist_n = hist_q;
    if (en) hist_n = {hist_q[W-3:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '1;
    else        hist_q <= hist_n;
  end

  assign hit = en && ({hist_q, din} == PATTERN);
endmodule

// File: rtl/cfg_chain_frames.sv
module cfg_chain_frames #(
  parameter int unsigned FRAME_BITS = 8,
  parameter int unsigned NUM_FRAMES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic din,
  output logic bit_valid,
  output logic done
);
  localparam int unsigned IDX_W = $clog2(FRAME_BITS + 1);
  localparam int unsigned FCN_W = $clog2(NUM_FRAMES + 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BITS - 1);
  localparam logic [FCN_W-1:0] FCN_LAST = FCN_W'(NUM_FRAMES - 1);

  logic             busy_q, busy_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic [FCN_W-1:0] fcnt_q, fcnt_n;

  always_comb begin
    busy_n    = busy_q;
    idx_n     = idx_q;
    fcnt_n    = fcnt_q;
    bit_valid = 1'b0;
    done      = 1'b0;
    if (en) begin
      if (!busy_q) begin
        if (!din) begin
          busy_n = 1'b1;
          idx_n  = '0;
        end
      end else begin
        bit_valid = 1'b1;
        if (idx_q == IDX_LAST) begin
          busy_n = 1'b0;
          fcnt_n = fcnt_q + 1'b1;
          if (fcnt_q == FCN_LAST) done = 1'b1;
        end else begin
          idx_n = idx_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      fcnt_q <= '0;
    end else begin
      busy_q <= busy_n;
      idx_q  <= idx_n;
      fcnt_q <= fcnt_n;
    end
  end

  // R6: a one while waiting for a start bit leaves the frame closed
  a_r6_fill_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !busy_q && din) |=> !busy_q);
  // R10: the frame counter never passes the configured frame count
  a_r10_frame_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt_q <= FCN_W'(NUM_FRAMES));
endmodule

// File: rtl/cfg_chain_startup.sv
module cfg_chain_startup #(
  parameter int unsigned LEN_W     = 24,
  parameter int unsigned REL_DELAY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic len_shift,
  input  logic len_last,
  input  logic din,
  output logic startup,
  output logic io_release
);
  logic [LEN_W-1:0]     len_q, len_n;
  logic                 len_ok_q, len_ok_n;
  logic [LEN_W-1:0]     cnt_q, cnt_n;
  logic                 start_q, start_n;
  logic [REL_DELAY-1:0] rel_q, rel_n;
  logic [LEN_W:0]       bit_num;

  assign bit_num = {1'b0, cnt_q} + 1'b1;

  always_comb begin
    len_n    = len_q;
    len_ok_n = len_ok_q;
    cnt_n    = cnt_q;
    start_n  = start_q;
    if (len_shift) len_n = {len_q[LEN_W-2:0], din};
    if (len_last)  len_ok_n = 1'b1;
    if (cnt_q != '1) cnt_n = cnt_q + 1'b1;
    if (len_ok_q && (bit_num == {1'b0, len_q})) start_n = 1'b1;
  end

  generate
    if (REL_DELAY == 1) begin : g_rel_one
      assign rel_n = start_q;
    end else begin : g_rel_chain
      assign rel_n = {rel_q[REL_DELAY-2:0], start_q};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q    <= '0;
      len_ok_q <= 1'b0;
      cnt_q    <= '0;
      start_q  <= 1'b0;
      rel_q    <= '0;
    end else begin
      len_q    <= len_n;
      len_ok_q <= len_ok_n;
      cnt_q    <= cnt_n;
      start_q  <= start_n;
      rel_q    <= rel_n;
    end
  end

  assign startup    = start_q;
  assign io_release = rel_q[REL_DELAY-1];

  a_r8_startup_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    startup |=> startup);
  a_r9_release_after_startup: assert property (@(posedge clk) disable iff (!rst_n)
    io_release |-> startup);
  a_r9_release_not_early: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(startup) |-> !io_release);
endmodule

// File: rtl/cfg_chain_rx.sv
module cfg_chain_rx #(
  parameter int unsigned FRAME_BITS = 8,
  parameter int unsigned NUM_FRAMES = 2,
  parameter int unsigned LEN_W      = 24,
  parameter int unsigned REL_DELAY  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_in,
  output logic ser_out,
  output logic frame_valid,
  output logic frame_bit,
  output logic startup,
  output logic io_release
);
  import cfg_chain_pkg::*;

  localparam int unsigned LC_W = $clog2(LEN_W + 1);
  localparam logic [LC_W-1:0] LC_LAST = LC_W'(LEN_W - 1);

  chain_state_e    state_q, state_n;
  logic [LC_W-1:0] lcnt_q, lcnt_n;
  logic            dout_q, dout_n;
  logic            fv_q, fb_q;
  logic            pre_hit, fr_valid, fr_done, len_last;

  cfg_chain_preamble #(.W(PRE_W), .PATTERN(PRE_PATTERN)) u_pre (
    .clk(clk), .rst_n(rst_n), .en(state_q == ST_SEARCH), .din(ser_in), .hit(pre_hit));

  cfg_chain_frames #(.FRAME_BITS(FRAME_BITS), .NUM_FRAMES(NUM_FRAMES)) u_frames (
    .clk(clk), .rst_n(rst_n), .en(state_q == ST_FRAMES), .din(ser_in),
    .bit_valid(fr_valid), .done(fr_done));

  cfg_chain_startup #(.LEN_W(LEN_W), .REL_DELAY(REL_DELAY)) u_start (
    .clk(clk), .rst_n(rst_n), .len_shift(state_q == ST_LENGTH), .len_last(len_last),
    .din(ser_in), .startup(startup), .io_release(io_release));

  assign len_last = (state_q == ST_LENGTH) && (lcnt_q == LC_LAST);

  always_comb begin
    state_n = state_q;
    lcnt_n  = lcnt_q;
    unique case (state_q)
      ST_SEARCH: if (pre_hit) begin
        state_n = ST_LENGTH;
        lcnt_n  = '0;
      end
      ST_LENGTH: begin
        if (len_last) state_n = ST_FRAMES;
        else          lcnt_n  = lcnt_q + 1'b1;
      end
      ST_FRAMES: if (fr_done) state_n = ST_PASS;
      ST_PASS:   state_n = ST_PASS;
      default:   state_n = ST_SEARCH;
    endcase
    dout_n = (state_q == ST_FRAMES) ? 1'b1 : ser_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SEARCH;
      lcnt_q  <= '0;
      dout_q  <= 1'b1;
      fv_q    <= 1'b0;
      fb_q    <= 1'b0;
    end else begin
      state_q <= state_n;
      lcnt_q  <= lcnt_n;
      dout_q  <= dout_n;
      fv_q    <= fr_valid;
      fb_q    <= ser_in;
    end
  end

  assign ser_out     = dout_q;
  assign frame_valid = fv_q;
  assign frame_bit   = fb_q;

  a_r5_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FRAMES) |=> ser_out);
  a_r7_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PASS) |=> (ser_out == $past(ser_in)));
  a_r5_valid_only_in_frames: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_FRAMES) |=> !frame_valid);
  a_r2_search_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SEARCH) |=> (ser_out == $past(ser_in)));
endmodule

// File: tb/cfg_chain_rx_bench.sv
module cfg_chain_rx_bench;
  localparam int FB = 4;
  localparam int NF = 3;
  localparam int MAXN = 128;

  logic clk, rst_n, ser_in;
  logic ser_out, frame_valid, frame_bit, startup, io_release;

  cfg_chain_rx #(.FRAME_BITS(FB), .NUM_FRAMES(NF)) u_cfg_chain_rx (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .ser_out(ser_out),
    .frame_valid(frame_valid), .frame_bit(frame_bit),
    .startup(startup), .io_release(io_release));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  logic stream [MAXN];
  logic e_dout [MAXN];
  logic e_fv   [MAXN];
  logic e_fb   [MAXN];
  int   seg    [MAXN];
  int   nbits;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input logic b, input logic d, input logic fv, input int sg);
    stream[nbits] = b;
    e_dout[nbits] = d;
    e_fv[nbits]   = fv;
    e_fb[nbits]   = fv ? b : 1'b0;
    seg[nbits]    = sg;
    nbits++;
  endtask

  function automatic string seg_tag(input int sg);
    case (sg)
      2: seg_tag = "R2";
      3: seg_tag = "R3";
      4: seg_tag = "R4";
      5: seg_tag = "R5";
      6: seg_tag = "R6";
      default: seg_tag = "R7";
    endcase
  endfunction

  task automatic run_scen(input int idle, input int gap, input int s, input int tail, input int back);
    int len;
    int fv_count;
    logic b;
    nbits = 0;
    for (int i = 0; i < idle; i++) begin
      b = (i % 3 == 0) ? 1'b0 : 1'b1;
      push(b, b, 1'b0, 2);
    end
    push(1'b0, 1'b0, 1'b0, 3); push(1'b0, 1'b0, 1'b0, 3);
    push(1'b1, 1'b1, 1'b0, 3); push(1'b0, 1'b0, 1'b0, 3);
    // total length: header so far + 24 + frames + tail
    len = nbits + 24 + NF * (gap + 1 + FB) + tail - back;
    for (int k = 23; k >= 0; k--) begin
      b = len[k];
      push(b, b, 1'b0, 4);
    end
    for (int f = 0; f < NF; f++) begin
      for (int g = 0; g < gap + (f % 2); g++) push(1'b1, 1'b1, 1'b0, 6);
      push(1'b0, 1'b1, 1'b0, 6);
      for (int d = 0; d < FB; d++) begin
        b = (((f * 7 + d * 3 + s) % 5) < 2);
        push(b, 1'b1, 1'b1, 5);
      end
    end
    for (int t = 0; t < tail; t++) begin
      b = (((t * 5 + s) % 3) == 0);
      push(b, b, 1'b0, 7);
    end
    if (gap + (NF > 1) > gap) len = len + (NF / 2) - 0;
    // R8: length counts bits; recompute against the real stream length
    len = nbits - back;
    // redo the 24 length bits with the corrected value
    for (int k = 0; k < 24; k++) begin
      stream[idle + 4 + (23 - k)] = len[k];
      e_dout[idle + 4 + (23 - k)] = len[k];
    end

    rst_n = 1'b0;
    ser_in = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(ser_out == 1'b1, "R1 ser_out in reset", ser_out, 1);
    chk(startup == 1'b0 && io_release == 1'b0, "R1 startup/release in reset", startup, 0);
    chk(frame_valid == 1'b0, "R1 frame_valid in reset", frame_valid, 0);
    rst_n = 1'b1;
    fv_count = 0;
    for (int i = 0; i < nbits; i++) begin
      ser_in = stream[i];
      @(posedge clk); #1;
      chk(ser_out == e_dout[i], seg_tag(seg[i]), ser_out, e_dout[i]);
      chk(frame_valid == e_fv[i], (seg[i] == 6) ? "R6 frame_valid" : "R5 frame_valid",
          frame_valid, e_fv[i]);
      if (e_fv[i]) chk(frame_bit == e_fb[i], "R5 frame_bit", frame_bit, e_fb[i]);
      if (frame_valid) fv_count++;
      chk(startup == (i + 1 >= len), "R8 startup", startup, (i + 1 >= len));
      chk(io_release == (i + 1 >= len + 2), "R9 io_release", io_release, (i + 1 >= len + 2));
      @(negedge clk);
    end
    chk(fv_count == FB * NF, "R10 frame bit count", fv_count, FB * NF);
  endtask

  initial begin
    rst_n = 1'b0;
    ser_in = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(ser_out == 1'b1, "R1 initial ser_out", ser_out, 1);
    for (int ii = 0; ii < 3; ii++)
      for (int gg = 0; gg < 3; gg++)
        for (int bb = 0; bb < 2; bb++)
          run_scen(ii * 3, gg, ii * 6 + gg * 2 + bb, 5 + gg, 3 + bb);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule